// File: doc/BRIEF.md
# Phase-Programmable Pixel Output Stage

This block drives the 12-bit pixel output bus and its companion data clock for a sensor front end. It runs on a fast clock that divides each pixel period into 48 sub-pixel slots. An external counter supplies the current slot number. A capture strobe marks the slot in which the processed sample is valid. Each captured sample goes through a fixed delay line of 11 pixel periods, and is then launched on the bus in one programmable slot of the pixel period.

The data clock has two modes, chosen by a control bit. In the tracking mode it rises in the same slot as the data launch, with a 50% duty cycle. In the fixed mode it is locked to the inverted pixel clock, high during slots 24 to 47, whatever the launch slot. A 2-bit delay setting in the control word stands for an analog output delay that lies outside this logic, so it has no effect here.

The sample input is a stream with `capture_stb` as its valid signal and no ready. The pixel rate cannot stall, so the block never back-pressures. A source that strobes more than once in a pixel period overwrites the earlier capture. The output has no handshake: a new word is presented once per pixel period, in the launch slot.

Top module: `pixout_stage`

## Requirements
- R1: While reset is asserted, and after reset until the first sample has passed through the delay line, `dout` is zero. `dclk_out` is low while reset is asserted.
- R2: A sample captured in pixel period n is the value `dout` takes at the launch edge of pixel period n+11. A pixel period ends with the cycle whose `slot_idx` is 47.
- R3: `dout` changes only at the clock edge that ends a cycle whose `slot_idx` equals the effective launch slot. The launch slot is taken from `ctrl_word[5:0]`.
- R4: A launch slot value of 48 to 63 in `ctrl_word[5:0]` acts as slot 0, both for the data launch and for the tracking data clock.
- R5: When `ctrl_word[6]` is 0 (tracking mode), `dclk_out` is high after the edge of a slot s exactly when (s - launch slot) mod 48 is below 24. It therefore rises at the same edge as `dout` and stays high for 24 slots.
- R6: When `ctrl_word[6]` is 1 (fixed mode), `dclk_out` is high after the edge of slot s exactly when s is 24 or more, whatever the launch slot.
- R7: `ctrl_word[8:7]` (output-delay setting) has no effect on `dout` or `dclk_out`, even when it changes every cycle.
- R8: When several strobes occur in one pixel period, the last one wins. A period with no strobe carries the most recently captured sample.
- R9: A strobe in slot 47 belongs to the pixel period that slot ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-rate clock, 48 cycles per pixel period |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_idx | input | 6 | Current sub-pixel slot, 0 to 47 |
| capture_stb | input | 1 | Sample valid strobe; no ready, cannot be stalled |
| pix_in | input | 12 | Processed pixel sample |
| ctrl_word | input | 9 | [5:0] launch slot, [6] clock mode, [8:7] delay setting (no effect) |
| dout | output | 12 | Launched pixel data |
| dclk_out | output | 1 | Data clock |

## Verification
Some properties are checked on every cycle. `dout` holds outside the launch slot. The tracking clock rises with each launch. The fixed-mode clock follows the slot halves. An out-of-range launch value wraps to slot 0. The delay-line tap holds between pixel boundaries, and a slot-47 strobe enters the first stage. The exact 11-period latency, last-strobe-wins, the carry-over of a held sample and the zero output before the pipeline fills all depend on sample values across many pixel periods. Only the bench scenarios, which compare every cycle against a model built from the requirements, can show those. The same holds for the immunity to the delay bits.

// File: rtl/pixout_pkg.sv
package pixout_pkg;
  localparam int DEF_DATA_W  = 12;
  localparam int DEF_SLOTS   = 48;
  localparam int DEF_LATENCY = 11;

  typedef enum logic {
    DCLK_TRACK = 1'b0,
    DCLK_FIXED = 1'b1
  } dclk_mode_e;
endpackage

// File: rtl/slot_phase_decode.sv
module slot_phase_decode
  import pixout_pkg::*;
#(
  parameter int SLOTS = DEF_SLOTS,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] slot_idx,
  input  logic [SW-1:0] phase_raw,
  input  dclk_mode_e    mode,
  output logic          launch,
  output logic          tick,
  output logic          dclk_next
);
  localparam logic [SW:0] SLOTS_X = (SW+1)'(SLOTS);
  localparam logic [SW:0] HALF_X  = (SW+1)'(SLOTS / 2);
  localparam logic [SW:0] LAST_X  = (SW+1)'(SLOTS - 1);

  logic [SW:0] slot_x, eff_x, off_x;

  always_comb begin
    slot_x = {1'b0, slot_idx};
    // out-of-range launch values fall back to slot 0
    eff_x  = ({1'b0, phase_raw} >= SLOTS_X) ? '0 : {1'b0, phase_raw};
    off_x  = (slot_x >= eff_x) ? (slot_x - eff_x) : (slot_x + SLOTS_X - eff_x);
    launch = (slot_x == eff_x);
    tick   = (slot_x == LAST_X);
    if (mode == DCLK_FIXED) dclk_next = (slot_x >= HALF_X);
    else                    dclk_next = (off_x < HALF_X);
  end

  // R4: the decoded launch slot never leaves the legal range
  p_eff_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eff_x < SLOTS_X);
endmodule

// File: rtl/pixel_delay_line.sv
module pixel_delay_line
  import pixout_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int LATENCY = DEF_LATENCY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              stb,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] tap
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] cap;
  logic [DATA_W-1:0] stage_q [LATENCY];

  // a strobe in the boundary slot is taken directly (R9)
  assign cap = stb ? din : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hold_q <= '0;
    else if (stb) hold_q <= din;
  end

  for (genvar g = 0; g < LATENCY; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    stage_q[0] <= '0;
        else if (tick) stage_q[0] <= cap;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    stage_q[g] <= '0;
        else if (tick) stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign tap = stage_q[LATENCY-1];

  // R2: the line only advances at pixel boundaries
  p_tap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tap));
  // R9: boundary-slot strobe lands in the first stage
  p_edge_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stb) |=> stage_q[0] == $past(din));
endmodule

// File: rtl/pixout_stage.sv
module pixout_stage
  import pixout_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int SLOTS   = DEF_SLOTS,
  parameter int LATENCY = DEF_LATENCY,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = SW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     slot_idx,
  input  logic              capture_stb,
  input  logic [DATA_W-1:0] pix_in,
  input  logic [CW-1:0]     ctrl_word,
  output logic [DATA_W-1:0] dout,
  output logic              dclk_out
);
  localparam logic [SW-1:0] HALF_S = SW'(SLOTS / 2);

  logic              launch, tick, dclk_next;
  logic [DATA_W-1:0] tap;
  dclk_mode_e        mode;
  logic              unused_delay_bits;

  assign mode              = dclk_mode_e'(ctrl_word[SW]);
  assign unused_delay_bits = ^ctrl_word[CW-1:SW+1];

  slot_phase_decode #(.SLOTS(SLOTS)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_idx  (slot_idx),
    .phase_raw (ctrl_word[SW-1:0]),
    .mode      (mode),
    .launch    (launch),
    .tick      (tick),
    .dclk_next (dclk_next)
  );

  pixel_delay_line #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .stb   (capture_stb),
    .din   (pix_in),
    .tap   (tap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dclk_out <= 1'b0;
    end else begin
      if (launch) dout <= tap;
      dclk_out <= dclk_next;
    end
  end

  // R1: outputs are cleared while reset is held
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (dout == '0 && !dclk_out));
  // R3: data moves only at the launch edge
  p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(dout));
  // R5: tracking clock rises together with the data launch
  p_track_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !ctrl_word[SW] && $stable(ctrl_word[SW:0])) |=> $rose(dclk_out));
  // R6: fixed clock follows the slot halves
  p_fixed_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[SW] && slot_idx >= HALF_S) |=> dclk_out);
  p_fixed_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[SW] && slot_idx < HALF_S) |=> !dclk_out);
  // R4: an out-of-range launch value acts as slot 0
  p_wrap_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ctrl_word[SW-1:0]} >= (SW+1)'(SLOTS) && !ctrl_word[SW] && slot_idx == '0)
      |=> dclk_out);
endmodule

// File: tb/tb_pixout_stage.sv
module tb_pixout_stage;
  localparam int SLOTS = 48;
  localparam int LAT   = 11;
  localparam int NPIX  = 14;

  typedef struct packed {
    logic [5:0] ph;
    logic       mode;
    logic [1:0] dly;
    logic [5:0] sa;
    logic [5:0] sb;
    logic       even;
    logic [3:0] tag;
  } vec_t;

  // launch slot, clock mode, delay bits, strobe slot A, strobe slot B (63 = none),
  // strobe only on even pixels, requirement tag
  localparam vec_t VECS [9] = '{
    '{6'd0,  1'b0, 2'd2, 6'd5,  6'd63, 1'b0, 4'd2},  // R2 baseline latency
    '{6'd20, 1'b0, 2'd0, 6'd30, 6'd63, 1'b0, 4'd3},  // R3 mid-period launch
    '{6'd47, 1'b0, 2'd1, 6'd47, 6'd63, 1'b0, 4'd9},  // R9 strobe in last slot
    '{6'd55, 1'b0, 2'd3, 6'd10, 6'd63, 1'b0, 4'd4},  // R4 out-of-range launch
    '{6'd63, 1'b1, 2'd2, 6'd0,  6'd63, 1'b0, 4'd4},  // R4 with fixed clock
    '{6'd13, 1'b1, 2'd0, 6'd40, 6'd63, 1'b0, 4'd6},  // R6 fixed clock
    '{6'd33, 1'b0, 2'd3, 6'd2,  6'd44, 1'b0, 4'd8},  // R8 two strobes
    '{6'd8,  1'b0, 2'd2, 6'd12, 6'd63, 1'b1, 4'd8},  // R8 carry-over
    '{6'd24, 1'b0, 2'd0, 6'd23, 6'd63, 1'b0, 4'd5}   // R5 tracking clock
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [5:0]  slot_idx = '0;
  logic        capture_stb = 1'b0;
  logic [11:0] pix_in = '0;
  logic [8:0]  ctrl_word = '0;
  logic [11:0] dout;
  logic        dclk_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [11:0] hist [NPIX];
  logic [11:0] hold_m, exp_dout;
  logic        exp_dclk;

  always #4 clk = ~clk;

  pixout_stage dut (
    .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .capture_stb(capture_stb),
    .pix_in(pix_in), .ctrl_word(ctrl_word), .dout(dout), .dclk_out(dclk_out)
  );

  task automatic check(input int tag, input string what, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // R1: outputs zero while reset is held
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    capture_stb = 1'b0;
    slot_idx = '0;
    @(negedge clk);
    check(1, "dout in reset", dout, 12'h000);
    check(1, "dclk in reset", {11'b0, dclk_out}, 12'h000);
    rst_n = 1'b1;
    hold_m = '0; exp_dout = '0; exp_dclk = 1'b0;
    for (int i = 0; i < NPIX; i++) hist[i] = '0;
  endtask

  task automatic run_pixels(input vec_t v, input int idx, input int npix, input bit wiggle);
    int eff;
    eff = (v.ph >= 6'd48) ? 0 : int'(v.ph);
    for (int p = 0; p < npix; p++) begin
      for (int s = 0; s < SLOTS; s++) begin
        logic stb;
        logic [11:0] data;
        stb  = ((s == int'(v.sa)) || (s == int'(v.sb))) && (!v.even || (p % 2 == 0));
        data = 12'((idx * 331 + p * 37 + s * 5 + 1) & 12'hFFF);
        slot_idx    = 6'(s);
        capture_stb = stb;
        pix_in      = data;
        ctrl_word   = {(wiggle ? 2'(p + s) : v.dly), v.mode, v.ph};  // R7 wiggle
        @(posedge clk);
        if (stb) hold_m = data;
        if (s == SLOTS - 1) hist[p] = hold_m;
        if (s == eff) exp_dout = (p >= LAT) ? hist[p - LAT] : 12'h000;
        exp_dclk = v.mode ? (s >= SLOTS / 2) : (((s - eff + SLOTS) % SLOTS) < SLOTS / 2);
        @(negedge clk);
        check(wiggle ? 7 : int'(v.tag), "dout", dout, exp_dout);
        check(wiggle ? 7 : (v.mode ? 6 : 5), "dclk", {11'b0, dclk_out}, {11'b0, exp_dclk});
      end
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    // R1: check before any sample arrives
    do_reset();
    for (int i = 0; i < 9; i++) begin
      do_reset();
      run_pixels(VECS[i], i, NPIX, 1'b0);
    end
    // R7: delay bits toggle every cycle without effect
    do_reset();
    run_pixels('{6'd30, 1'b0, 2'd0, 6'd17, 6'd63, 1'b0, 4'd7}, 11, NPIX, 1'b1);
    // R1: reset in mid-run clears a filled pipeline
    do_reset();
    run_pixels(VECS[0], 12, 12, 1'b0);
    check(2, "dout filled before reset", {11'b0, dout != 12'h000}, 12'h001);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "dout after mid-run reset", dout, 12'h000);
    check(1, "dclk after mid-run reset", {11'b0, dclk_out}, 12'h000);
    rst_n = 1'b1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule